// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst access to a synchronous memory. When either of two address-strobe inputs is asserted, it registers the incoming address and starts a new burst at beat zero. On each later clock edge where the active-low advance input is low, the beat index steps by one. The low two bits of the output address are formed from the captured low bits and the beat index, in one of two orders.

A mode pin chooses the order. With mode low, the order is linear: start plus beat, modulo four. With mode high, the order is interleaved: start XOR beat. The upper address bits come straight from the captured address and stay the same for the whole burst. Holding advance high suspends the burst. A new strobe in the middle of a burst drops the current sequence and restarts from the new address.

Top module: `burst_seq_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a rising edge, the captured address and the beat index are cleared to zero, so `wordAddr` and `beatIdx` read zero after that edge.
- R2: At a rising edge where `strobeHost` or `strobeCtl` is high, `addrIn` is captured and `beatIdx` becomes 0. After that edge, `wordAddr` equals `addrIn` in either mode.
- R3: At a rising edge with no strobe high and `advanceN` low, `beatIdx` increases by one. The increase is modulo 4.
- R4: At a rising edge with no strobe high and `advanceN` high, `beatIdx` and the captured address keep their values, so `wordAddr` does not change.
- R5: When `mode` is 0, bits [1:0] of `wordAddr` equal (captured bits [1:0] + `beatIdx`) modulo 4.
- R6: When `mode` is 1, bits [1:0] of `wordAddr` equal captured bits [1:0] XOR `beatIdx`.
- R7: Bits above bit 1 of `wordAddr` always equal the same bits of the last captured address, whatever the beat or the mode.
- R8: A strobe has priority over advance. In a cycle where a strobe and a low `advanceN` are both present, the advance is ignored and `beatIdx` becomes 0.
- R9: After four advances from a load, `wordAddr` returns to the captured starting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobeHost | input | 1 | Host-side address strobe, active high |
| strobeCtl | input | 1 | Controller-side address strobe, active high |
| advanceN | input | 1 | Burst advance, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | Start address for a new access |
| wordAddr | output | ADDR_W | Current word address |
| beatIdx | output | 2 | Current beat index within the burst |

## Verification
The hardest case to reach is a reload that lands in the same cycle as an advance, in the middle of a burst that has been suspended or has just wrapped. In that case, only the strobe priority decides whether the new burst starts at beat zero. The stimulus walks full bursts in both orders and inserts suspensions. It then runs a long stretch of randomly mixed strobes, advances and mode changes, with strobes biased so that they often collide with advances. A behavioural model in the bench checks every cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic load;
    logic step;
  } seqCtrl_t;

  function automatic logic [BEAT_W-1:0] orderLow(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input logic              interleaved
  );
    return interleaved ? (start ^ beat) : BEAT_W'(start + beat);
  endfunction
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic     strobeHost,
  input  logic     strobeCtl,
  input  logic     advanceN,
  output seqCtrl_t ctrl
);
  always_comb begin
    ctrl.load = strobeHost | strobeCtl;
    ctrl.step = ~advanceN;
  end
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtrl_t          ctrl,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [BEAT_W-1:0] beatIdx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] beatQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ <= '0;
      beatQ <= '0;
    end else if (ctrl.load) begin
      baseQ <= addrIn;
      beatQ <= '0;
    end else if (ctrl.step) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  always_comb begin
    wordAddr = {baseQ[ADDR_W-1:BEAT_W], orderLow(baseQ[BEAT_W-1:0], beatQ, mode)};
    beatIdx  = beatQ;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (beatQ == '0 && baseQ == '0));
  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> (beatQ == '0 && baseQ == $past(addrIn)));
  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.load && ctrl.step) |=> beatQ == BEAT_W'($past(beatQ) + 1'b1));
  // R4
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.load && !ctrl.step) |=> ($stable(beatQ) && $stable(baseQ)));
  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> $stable(wordAddr[ADDR_W-1:BEAT_W]));
  // R8
  load_over_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && ctrl.step) |=> beatQ == '0);
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobeHost,
  input  logic              strobeCtl,
  input  logic              advanceN,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [BEAT_W-1:0] beatIdx
);
  seqCtrl_t ctrl;

  burst_seq_ctrl u_ctrl (
    .strobeHost (strobeHost),
    .strobeCtl  (strobeCtl),
    .advanceN   (advanceN),
    .ctrl       (ctrl)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .mode     (mode),
    .addrIn   (addrIn),
    .wordAddr (wordAddr),
    .beatIdx  (beatIdx)
  );
endmodule

// File: tb/burst_seq_gen_tb.sv
`timescale 1ns/1ps
module burst_seq_gen_tb;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strobeHost = 1'b0;
  logic          strobeCtl = 1'b0;
  logic          advanceN = 1'b1;
  logic          mode = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] wordAddr;
  logic [1:0]    beatIdx;

  int checks = 0;
  int failures = 0;

  integer mBase = 0;
  integer mBeat = 0;

  always #10 clk = ~clk;

  burst_seq_gen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .strobeHost(strobeHost), .strobeCtl(strobeCtl),
    .advanceN(advanceN), .mode(mode), .addrIn(addrIn),
    .wordAddr(wordAddr), .beatIdx(beatIdx)
  );

  function automatic integer expAddr();
    integer lo;
    integer st;
    st = mBase % 4;
    if (mode) lo = st ^ mBeat;
    else      lo = (st + mBeat) % 4;
    return (mBase / 4) * 4 + lo;
  endfunction

  task automatic compare(input string req);
    integer ea;
    ea = expAddr();
    checks++;
    if (wordAddr !== AW'(ea) || beatIdx !== 2'(mBeat)) begin
      failures++;
      $display("FAIL %s: wordAddr=%h beatIdx=%0d expected wordAddr=%h beatIdx=%0d",
               req, wordAddr, beatIdx, AW'(ea), mBeat);
    end
  endtask

  task automatic cyc(input logic r, input logic sh, input logic sc, input logic an,
                     input logic md, input logic [AW-1:0] a, input string req);
    rst = r; strobeHost = sh; strobeCtl = sc; advanceN = an; mode = md; addrIn = a;
    @(posedge clk);
    #1;
    if (r) begin
      mBase = 0; mBeat = 0;
    end else if (sh || sc) begin
      mBase = int'(a); mBeat = 0;          // R2, R8
    end else if (!an) begin
      mBeat = (mBeat + 1) % 4;             // R3
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    cyc(1, 0, 0, 1, 0, '0, "R1");
    cyc(1, 0, 0, 0, 0, 17'h1ABCD, "R1");

    // R2 host strobe, linear burst, wrap (R5, R9)
    cyc(0, 1, 0, 1, 0, 17'h1ABCD, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, '0, "R5");
    compare("R9");
    // R4 suspend
    cyc(0, 0, 0, 0, 0, '0, "R3");
    cyc(0, 0, 0, 1, 0, 17'h00003, "R4");
    cyc(0, 0, 0, 1, 0, 17'h00003, "R4");

    // R6 interleaved burst from controller strobe, upper bits kept (R7)
    cyc(0, 0, 1, 1, 1, 17'h0F0F2, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 17'h1FFFF, "R6");
    compare("R9");
    compare("R7");

    // R8 strobe with advance mid-burst
    cyc(0, 0, 0, 0, 1, '0, "R6");
    cyc(0, 1, 0, 0, 1, 17'h15557, "R8");
    cyc(0, 0, 0, 0, 1, '0, "R6");
    cyc(0, 1, 1, 0, 0, 17'h0A0A1, "R8");
    cyc(0, 0, 0, 0, 0, '0, "R5");

    // randomized mix
    for (int i = 0; i < 600; i++) begin
      logic r, sh, sc, an, md;
      r  = ($urandom % 50) == 0;
      sh = ($urandom % 6) == 0;
      sc = ($urandom % 7) == 0;
      an = ($urandom % 4) == 0;
      md = ($urandom % 10) == 0 ? ~mode : mode;
      cyc(r, sh, sc, an, md, AW'($urandom), md ? "R6" : "R5");
    end

    // R1 reset mid-burst
    cyc(0, 1, 0, 1, 0, 17'h12345, "R2");
    cyc(0, 0, 0, 0, 0, '0, "R3");
    cyc(1, 0, 0, 0, 0, '0, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule